// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

The block picks one interrupt to hand to the processor from a set of maskable request lines. Each line has a 4-bit priority value held in an 8-bit slot, and four slots are packed into each 32-bit configuration word. A global grouping input splits the 4-bit value into a preemption field (upper bits) and a sub-priority field (lower bits). Among all enabled, pending lines the block selects a winner by its 4-bit value. When both fields tie, the line that has been pending longest wins, and a remaining tie goes to the lowest index.

The block keeps a small stack of the preemption levels of the handlers that are running. It offers the winner on the dispatch outputs only when the winner may run. That means no handler is active, or the winner's preemption field is strictly better than the running one's and the stack has room. The core signals entry into the offered handler with an entry strobe, which pushes the offered preemption level. It signals return with an exit strobe, which pops that level. The source of the request clears its own request line while its handler runs.

Top module: `gpa_arbiter`

## Requirements
- R1: A write with `cfg_we` high stores bits [8k+7:8k+4] of `cfg_wdata` as the priority of interrupt 4·`cfg_addr`+k, for k = 0..3, and leaves every other word unchanged. `cfg_rdata` shows word `cfg_addr` in the same layout, with bits [8k+3:8k] always zero.
- R2: An interrupt is pending when both its `irq_req` bit and its `irq_en` bit are 1. Only a pending interrupt is ever dispatched. After reset every priority is 0, `disp_valid` is 0 and `nest_lvl` is 0.
- R3: With g = `grp` (0..4), the preemption field is the upper g bits of the 4-bit priority and the sub-priority is the lower 4−g bits. `disp_pre` gives the preemption field of the offered interrupt.
- R4: Among pending interrupts, a smaller preemption field wins, and a smaller sub-priority breaks ties. This is the same as the smallest 4-bit priority value.
- R5: When two pending interrupts have equal priority values, the one that became pending in an earlier cycle wins. Interrupts that became pending in the same cycle are ordered by lowest index.
- R6: With `nest_lvl` = 0, the winning pending interrupt is offered.
- R7: With `nest_lvl` > 0, the winner is offered only if its preemption field is strictly smaller than `run_pre`. An equal preemption field with a better sub-priority is not offered.
- R8: `hnd_enter` while `disp_valid` is 1 pushes `disp_pre`, which raises `nest_lvl` by one and sets `run_pre` to the pushed value. `hnd_exit` pops one level and restores the previous `run_pre`. `hnd_exit` at `nest_lvl` = 0 has no effect.
- R9: While `nest_lvl` equals the stack depth (4), nothing is offered, even a better preemption level.
- R10: The dispatch outputs are registered and reflect inputs one clock later. In the cycle after any `hnd_enter` or `hnd_exit` strobe, `disp_valid` is 0.
- R11: `grp` values 5, 6 and 7 behave as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_IRQ | Request lines, one per interrupt |
| irq_en | input | N_IRQ | Per-interrupt enable |
| grp | input | 3 | Grouping: number of preemption bits |
| cfg_we | input | 1 | Priority word write strobe |
| cfg_addr | input | ADDR_W | Priority word index |
| cfg_wdata | input | 32 | Priority word write data, four 8-bit slots |
| cfg_rdata | output | 32 | Priority word at `cfg_addr`, low nibbles zero |
| hnd_enter | input | 1 | Core entered the offered handler |
| hnd_exit | input | 1 | Core returned from the current handler |
| disp_valid | output | 1 | An interrupt is offered |
| disp_id | output | ID_W | Index of the offered interrupt |
| disp_pre | output | 4 | Preemption field of the offered interrupt |
| nest_lvl | output | LVL_W | Number of active handlers |
| run_pre | output | 4 | Preemption level of the innermost active handler |

## Verification
The bench replays the three-interrupt grouping-2 case and expects the order 7, then 3, then 6. A design that compared only the preemption field, or nested on sub-priority, would serve 3 early or let it interrupt 7. It holds a better-sub-priority request against a running handler of equal preemption level, to catch a non-strict nesting compare. It fills the four-level stack and then raises a level-0 request, which an unguarded push would accept and overflow. It stages equal-priority requests a cycle apart with the later one at the lower index: an index-only tie-break would pick the wrong line. It also drives grouping 7, under which a design without the clamp would shift the priority wrongly and refuse to nest.

// File: rtl/gpa_pkg.sv
package gpa_pkg;

    localparam int PRIO_W         = 4;
    localparam int SLOT_W         = 8;
    localparam int SLOTS_PER_WORD = 4;
    localparam int CFG_W          = SLOT_W * SLOTS_PER_WORD;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [2:0]        grp_t;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    // Number of preemption bits; settings above 4 act as 4.
    function automatic int pre_bits(grp_t g);
        return (g > 3'd4) ? PRIO_W : int'(g);
    endfunction

    // Preemption field: the upper pre_bits(g) bits of the priority.
    function automatic prio_t pre_of(prio_t p, grp_t g);
        return p >> (PRIO_W - pre_bits(g));
    endfunction

endpackage

// File: rtl/gpa_prio_regs.sv
module gpa_prio_regs
    import gpa_pkg::*;
#(
    parameter int N_IRQ  = 16,
    parameter int ADDR_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CFG_W-1:0]     wdata,
    output prio_t                prio [N_IRQ],
    output logic [CFG_W-1:0]     rdata
);

    prio_t prio_q [N_IRQ];

    for (genvar i = 0; i < N_IRQ; i++) begin : g_slot
        localparam int WORD = i / SLOTS_PER_WORD;
        localparam int LSB  = (i % SLOTS_PER_WORD) * SLOT_W + (SLOT_W - PRIO_W);
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[i] <= '0;
            else if (we && addr == ADDR_W'(WORD))
                prio_q[i] <= wdata[LSB +: PRIO_W];
        end
        assign prio[i] = prio_q[i];
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < SLOTS_PER_WORD; k++) begin
            if (int'(addr) * SLOTS_PER_WORD + k < N_IRQ)
                rdata[k*SLOT_W + (SLOT_W - PRIO_W) +: PRIO_W] =
                    prio_q[int'(addr) * SLOTS_PER_WORD + k];
        end
    end

endmodule

// File: rtl/gpa_age_track.sv
module gpa_age_track #(
    parameter int N_IRQ = 16,
    parameter int AGE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] pend,
    output logic [AGE_W-1:0] age [N_IRQ]
);

    logic [AGE_W-1:0] age_q [N_IRQ];

    for (genvar i = 0; i < N_IRQ; i++) begin : g_age
        always_ff @(posedge clk) begin
            if (rst || !pend[i])
                age_q[i] <= '0;
            else if (age_q[i] != '1)
                age_q[i] <= age_q[i] + 1'b1;
        end
        assign age[i] = age_q[i];

        // R5: a line pending at one edge has a nonzero age at the next
        a_r5_age_starts: assert property (@(posedge clk) disable iff (rst)
            pend[i] |=> age_q[i] != '0);
    end

endmodule

// File: rtl/gpa_select.sv
module gpa_select
    import gpa_pkg::*;
#(
    parameter int N_IRQ = 16,
    parameter int AGE_W = 8,
    parameter int ID_W  = 4
) (
    input  logic [N_IRQ-1:0] pend,
    input  prio_t            prio [N_IRQ],
    input  logic [AGE_W-1:0] age  [N_IRQ],
    output logic             found,
    output logic [ID_W-1:0]  win_id,
    output prio_t            win_prio
);

    logic [AGE_W-1:0] win_age;

    // Preemption-then-sub ordering equals plain 4-bit order, so the
    // grouping plays no part here. Older wins a tie; the strict
    // compare in ascending index order leaves a full tie to the lowest.
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '0;
        win_age  = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (pend[i] && (!found || prio[i] < win_prio ||
                            (prio[i] == win_prio && age[i] > win_age))) begin
                found    = 1'b1;
                win_id   = ID_W'(i);
                win_prio = prio[i];
                win_age  = age[i];
            end
        end
    end

endmodule

// File: rtl/gpa_nest_stack.sv
module gpa_nest_stack
    import gpa_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    input  prio_t            push_val,
    output logic [LVL_W-1:0] level,
    output prio_t            top,
    output logic             full
);

    prio_t            stk_q [DEPTH];
    logic [LVL_W-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
        end else begin
            case (op)
                STK_PUSH: if (lvl_q != LVL_W'(DEPTH)) begin
                    stk_q[lvl_q] <= push_val;
                    lvl_q        <= lvl_q + 1'b1;
                end
                STK_POP: if (lvl_q != '0) lvl_q <= lvl_q - 1'b1;
                default: ;
            endcase
        end
    end

    assign level = lvl_q;
    assign full  = (lvl_q == LVL_W'(DEPTH));
    assign top   = (lvl_q == '0) ? '0 : stk_q[lvl_q - 1'b1];

    // R8: a push that has room makes the pushed level the top
    a_r8_push_top: assert property (@(posedge clk) disable iff (rst)
        (op == STK_PUSH && !full) |=> top == $past(push_val));

    // R8: a pop on an empty stack leaves it empty
    a_r8_pop_empty: assert property (@(posedge clk) disable iff (rst)
        (op == STK_POP && lvl_q == '0) |=> lvl_q == '0);

endmodule

// File: rtl/gpa_arbiter.sv
module gpa_arbiter
    import gpa_pkg::*;
#(
    parameter int N_IRQ      = 16,
    parameter int NEST_DEPTH = 4,
    parameter int AGE_W      = 8,
    localparam int ID_W   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
    localparam int WORDS  = (N_IRQ + SLOTS_PER_WORD - 1) / SLOTS_PER_WORD,
    localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LVL_W  = $clog2(NEST_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic [2:0]        grp,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              hnd_enter,
    input  logic              hnd_exit,
    output logic              disp_valid,
    output logic [ID_W-1:0]   disp_id,
    output logic [3:0]        disp_pre,
    output logic [LVL_W-1:0]  nest_lvl,
    output logic [3:0]        run_pre
);

    logic [N_IRQ-1:0] pend;
    prio_t            prio [N_IRQ];
    logic [AGE_W-1:0] age  [N_IRQ];
    logic             found;
    logic [ID_W-1:0]  win_id;
    prio_t            win_prio;
    prio_t            win_pre;
    prio_t            top;
    logic             full;
    logic             may_go;
    stk_op_e          op;

    logic             disp_valid_q;
    logic [ID_W-1:0]  disp_id_q;
    prio_t            disp_pre_q;

    assign pend = irq_req & irq_en;

    gpa_prio_regs #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .prio(prio), .rdata(cfg_rdata)
    );

    gpa_age_track #(.N_IRQ(N_IRQ), .AGE_W(AGE_W)) u_age (
        .clk(clk), .rst(rst), .pend(pend), .age(age)
    );

    gpa_select #(.N_IRQ(N_IRQ), .AGE_W(AGE_W), .ID_W(ID_W)) u_sel (
        .pend(pend), .prio(prio), .age(age),
        .found(found), .win_id(win_id), .win_prio(win_prio)
    );

    gpa_nest_stack #(.DEPTH(NEST_DEPTH), .LVL_W(LVL_W)) u_stk (
        .clk(clk), .rst(rst), .op(op), .push_val(disp_pre_q),
        .level(nest_lvl), .top(top), .full(full)
    );

    assign win_pre = pre_of(win_prio, grp_t'(grp));
    assign may_go  = found && !full && (nest_lvl == '0 || win_pre < top);

    always_comb begin
        if (hnd_exit)                       op = STK_POP;
        else if (hnd_enter && disp_valid_q) op = STK_PUSH;
        else                                op = STK_HOLD;
    end

    // Offer is suppressed for one cycle after a strobe so that it is
    // always recomputed against the updated stack.
    always_ff @(posedge clk) begin
        if (rst) begin
            disp_valid_q <= 1'b0;
            disp_id_q    <= '0;
            disp_pre_q   <= '0;
        end else begin
            disp_valid_q <= may_go && !hnd_enter && !hnd_exit;
            disp_id_q    <= win_id;
            disp_pre_q   <= win_pre;
        end
    end

    assign disp_valid = disp_valid_q;
    assign disp_id    = disp_id_q;
    assign disp_pre   = disp_pre_q;
    assign run_pre    = top;

    // R2: an offered line was pending when the offer was formed
    a_r2_from_pending: assert property (@(posedge clk) disable iff (rst)
        disp_valid_q |-> ($past(pend) & (N_IRQ'(1) << disp_id_q)) != '0);

    // R7: a nested offer is strictly better than the running level
    a_r7_strict_nest: assert property (@(posedge clk) disable iff (rst)
        (disp_valid_q && nest_lvl != '0) |-> disp_pre_q < top);

    // R9: no offer while the stack is full
    a_r9_full_quiet: assert property (@(posedge clk) disable iff (rst)
        full |-> !disp_valid_q);

    // R10: quiet in the cycle after a strobe
    a_r10_strobe_quiet: assert property (@(posedge clk) disable iff (rst)
        (hnd_enter || hnd_exit) |=> !disp_valid_q);

endmodule

// File: tb/tb_gpa_arbiter.sv
module tb_gpa_arbiter;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq_req = '0;
    logic [N-1:0] irq_en  = '1;
    logic [2:0]  grp = 3'd2;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        hnd_enter = 1'b0;
    logic        hnd_exit = 1'b0;
    logic        disp_valid;
    logic [3:0]  disp_id;
    logic [3:0]  disp_pre;
    logic [2:0]  nest_lvl;
    logic [3:0]  run_pre;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        bit    v;
        int    id;
        int    pre;
        int    nest;
        int    rp;
        string tag;
    } exp_t;

    exp_t q [$];
    logic [7:0] shadow [N];

    always #2 clk = ~clk;  // 250 MHz

    gpa_arbiter dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en), .grp(grp),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .hnd_enter(hnd_enter), .hnd_exit(hnd_exit),
        .disp_valid(disp_valid), .disp_id(disp_id), .disp_pre(disp_pre),
        .nest_lvl(nest_lvl), .run_pre(run_pre)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver side: wait for the edge, then queue what the outputs must be.
    task automatic tick(string tag, bit v, int id, int pre, int nest, int rp);
        exp_t e;
        @(posedge clk);
        e.v = v; e.id = id; e.pre = pre; e.nest = nest; e.rp = rp; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare queued expectations away from the active edge.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                e = q.pop_front();
                chk({e.tag, " valid"}, 32'(disp_valid), 32'(e.v));
                if (e.v) begin
                    chk({e.tag, " id"},  32'(disp_id),  e.id);
                    chk({e.tag, " pre"}, 32'(disp_pre), e.pre);
                end
                chk({e.tag, " nest"}, 32'(nest_lvl), e.nest);
                if (e.nest > 0) chk({e.tag, " run_pre"}, 32'(run_pre), e.rp);
            end
        end
    end

    function automatic logic [31:0] word_exp(int w);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[k*8 +: 8] = {shadow[w*4+k][7:4], 4'h0};
        return r;
    endfunction

    // Write one slot by rewriting its word; low nibbles carry junk.
    task automatic set_prio(int idx, logic [3:0] v);
        int w;
        shadow[idx] = {v, 4'hA};
        w = idx / 4;
        cfg_addr  = 2'(w);
        cfg_wdata = {shadow[w*4+3], shadow[w*4+2], shadow[w*4+1], shadow[w*4]};
        cfg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd_chk(string tag, int w);
        cfg_addr = 2'(w);
        #1;
        chk(tag, cfg_rdata, word_exp(w));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) shadow[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        tick("R2 reset", 0, 0, 0, 0, 0);
        rd_chk("R2 reset prio word 0", 0);

        // R1: writes land in their slots, low nibbles read zero
        set_prio(3, 4'h9);
        set_prio(6, 4'hC);
        set_prio(7, 4'h8);
        rd_chk("R1 word 1 readback", 1);
        rd_chk("R1 word 0 readback", 0);
        rd_chk("R1 word 2 untouched", 2);
        chk("R1 word 1 literal", cfg_rdata & 32'h0, 32'h0);
        cfg_addr = 2'd1; #1;
        chk("R1 word 1 value", cfg_rdata, 32'h80C0_0000);

        // R4 R3 R6: grouping 2 worked example, order 7, 3, 6
        grp = 3'd2;
        irq_req = 16'h00C8;
        tick("R4 first 7", 1, 7, 2, 0, 0);
        hnd_enter = 1; irq_req[7] = 0;
        tick("R10 after enter", 0, 0, 0, 1, 2);
        hnd_enter = 0;
        tick("R7 equal pre held", 0, 0, 0, 1, 2);
        hnd_exit = 1;
        tick("R8 pop", 0, 0, 0, 0, 0);
        hnd_exit = 0;
        tick("R4 second 3", 1, 3, 2, 0, 0);
        hnd_enter = 1; irq_req[3] = 0;
        tick("R8 push 3", 0, 0, 0, 1, 2);
        hnd_enter = 0;
        tick("R7 pre3 blocked", 0, 0, 0, 1, 2);
        hnd_exit = 1;
        tick("R8 pop 3", 0, 0, 0, 0, 0);
        hnd_exit = 0;
        tick("R6 third 6", 1, 6, 3, 0, 0);
        hnd_enter = 1; irq_req[6] = 0;
        tick("R8 push 6", 0, 0, 0, 1, 3);
        hnd_enter = 0; hnd_exit = 1;
        tick("R8 pop 6", 0, 0, 0, 0, 0);
        hnd_exit = 0;
        tick("R2 idle", 0, 0, 0, 0, 0);

        // R7 R8: nesting under grouping 2
        set_prio(8, 4'hC);
        set_prio(9, 4'h4);
        set_prio(10, 4'h0);
        set_prio(11, 4'h8);
        set_prio(12, 4'h5);
        irq_req[8] = 1;
        tick("R6 idle offer 8", 1, 8, 3, 0, 0);
        hnd_enter = 1; irq_req[8] = 0;
        tick("R8 push 8", 0, 0, 0, 1, 3);
        hnd_enter = 0; irq_req[12] = 1;
        tick("R7 nest 12", 1, 12, 1, 1, 3);
        hnd_enter = 1; irq_req[12] = 0;
        tick("R8 push 12", 0, 0, 0, 2, 1);
        hnd_enter = 0; irq_req[9] = 1;
        tick("R7 better sub no nest", 0, 0, 0, 2, 1);
        irq_req[10] = 1;
        tick("R7 nest 10", 1, 10, 0, 2, 1);
        hnd_enter = 1; irq_req[10] = 0;
        tick("R8 push 10", 0, 0, 0, 3, 0);
        hnd_enter = 0; hnd_exit = 1;
        tick("R8 pop to 12", 0, 0, 0, 2, 1);
        hnd_exit = 0;
        tick("R7 9 still held", 0, 0, 0, 2, 1);
        hnd_exit = 1;
        tick("R8 pop to 8", 0, 0, 0, 1, 3);
        hnd_exit = 0;
        tick("R7 nest 9", 1, 9, 1, 1, 3);
        hnd_enter = 1; irq_req[9] = 0;
        tick("R8 push 9", 0, 0, 0, 2, 1);
        hnd_enter = 0; hnd_exit = 1;
        tick("R8 pop a", 0, 0, 0, 1, 3);
        tick("R8 pop b", 0, 0, 0, 0, 0);
        tick("R8 pop empty ignored", 0, 0, 0, 0, 0);
        hnd_exit = 0;
        tick("R8 empty stays", 0, 0, 0, 0, 0);

        // R9: full stack under grouping 4
        grp = 3'd4;
        irq_req[8] = 1;
        tick("R9 offer 8", 1, 8, 12, 0, 0);
        hnd_enter = 1; irq_req[8] = 0;
        tick("R9 push 1", 0, 0, 0, 1, 12);
        hnd_enter = 0; irq_req[11] = 1;
        tick("R9 offer 11", 1, 11, 8, 1, 12);
        hnd_enter = 1; irq_req[11] = 0;
        tick("R9 push 2", 0, 0, 0, 2, 8);
        hnd_enter = 0; irq_req[12] = 1;
        tick("R9 offer 12", 1, 12, 5, 2, 8);
        hnd_enter = 1; irq_req[12] = 0;
        tick("R9 push 3", 0, 0, 0, 3, 5);
        hnd_enter = 0; irq_req[9] = 1;
        tick("R9 offer 9", 1, 9, 4, 3, 5);
        hnd_enter = 1; irq_req[9] = 0;
        tick("R9 push 4", 0, 0, 0, 4, 4);
        hnd_enter = 0; irq_req[10] = 1;
        tick("R9 full no offer", 0, 0, 0, 4, 4);
        tick("R9 full still none", 0, 0, 0, 4, 4);
        hnd_exit = 1;
        tick("R9 pop from full", 0, 0, 0, 3, 5);
        hnd_exit = 0;
        tick("R9 room offer 10", 1, 10, 0, 3, 5);
        irq_req[10] = 0;
        tick("R9 drop 10", 0, 0, 0, 3, 5);
        hnd_exit = 1;
        tick("R8 unwind a", 0, 0, 0, 2, 8);
        tick("R8 unwind b", 0, 0, 0, 1, 12);
        tick("R8 unwind c", 0, 0, 0, 0, 0);
        hnd_exit = 0;
        tick("R8 unwound", 0, 0, 0, 0, 0);

        // R11: grouping 7 acts as 4
        grp = 3'd7;
        irq_req[12] = 1;
        tick("R11 offer 12", 1, 12, 5, 0, 0);
        hnd_enter = 1; irq_req[12] = 0;
        tick("R11 push", 0, 0, 0, 1, 5);
        hnd_enter = 0; irq_req[9] = 1;
        tick("R11 nest 9", 1, 9, 4, 1, 5);
        hnd_enter = 1; irq_req[9] = 0;
        tick("R11 push 9", 0, 0, 0, 2, 4);
        hnd_enter = 0; hnd_exit = 1;
        tick("R11 pop a", 0, 0, 0, 1, 5);
        tick("R11 pop b", 0, 0, 0, 0, 0);
        hnd_exit = 0;

        // R3: grouping 3 and grouping 0 fields
        grp = 3'd3;
        irq_req[12] = 1;
        tick("R3 grp3 pre", 1, 12, 2, 0, 0);
        irq_req[12] = 0;
        tick("R3 drop", 0, 0, 0, 0, 0);
        grp = 3'd0;
        irq_req[8] = 1;
        tick("R3 grp0 pre zero", 1, 8, 0, 0, 0);
        hnd_enter = 1; irq_req[8] = 0;
        tick("R3 grp0 push", 0, 0, 0, 1, 0);
        hnd_enter = 0; irq_req[10] = 1;
        tick("R3 grp0 never nests", 0, 0, 0, 1, 0);
        hnd_exit = 1; irq_req[10] = 0;
        tick("R3 grp0 pop", 0, 0, 0, 0, 0);
        hnd_exit = 0;

        // R5: arrival order and same-cycle index order
        grp = 3'd2;
        set_prio(13, 4'h6);
        set_prio(14, 4'h6);
        set_prio(15, 4'h6);
        irq_req[14] = 1;
        tick("R5 first arrival 14", 1, 14, 1, 0, 0);
        irq_req[13] = 1;
        tick("R5 older 14 beats 13", 1, 14, 1, 0, 0);
        irq_req[15:13] = 3'b000;
        tick("R5 clear", 0, 0, 0, 0, 0);
        irq_req[15:13] = 3'b111;
        tick("R5 same cycle lowest", 1, 13, 1, 0, 0);
        irq_req[15:13] = 3'b000;
        tick("R5 clear b", 0, 0, 0, 0, 0);

        // R2: disabled request is not pending
        irq_en[10] = 0; irq_req[10] = 1;
        tick("R2 disabled none", 0, 0, 0, 0, 0);
        tick("R2 disabled still", 0, 0, 0, 0, 0);
        irq_en[10] = 1;
        tick("R2 enabled offer", 1, 10, 0, 0, 0);
        irq_req[10] = 0;
        tick("R2 final idle", 0, 0, 0, 0, 0);

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule